// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter that sits on a processor bus like a slow memory. When the processor pulls chip select and read low together, a conversion starts. The block divides its single input clock by two. It tells the track/hold switch when to stop tracking, and it steps a trial code onto the DAC one bit at a time. For each bit it takes a decision from a comparator flag. When it finishes, it loads the result into an output data latch. The bus drivers for that latch are enabled only while the block is selected.

All logic is clocked on the falling edge of the input clock, so "edge N" below means the N-th falling edge. Edge 1 is the first falling edge at which both request inputs are sampled low while the block is idle. The active-low busy flag is low from edge 1 until the end of the conversion. A processor that keeps the read active across the end of a conversion stalls the block. Busy then stays low and the result is not loaded until the read is released, so one long read both starts a conversion and waits for it. A read issued while a conversion runs returns the previous result.

The analog track/hold, the DAC and the comparator sit outside this block. The comparator arrives as a single digital flag.

Top module: `sar_adc_seq`

## Requirements
- R1: While `rstN` is low: `busyN` is 1, `holdOut` is 0, `dacCode` is 0x00 and the data latch reads 0x00.
- R2: When `csN` and `rdN` are both sampled low at a falling edge while idle, `busyN` goes low after that edge. With only one of them low, no conversion starts.
- R3: `holdOut` stays 0 after edges 1 and 2 and goes to 1 after edge 3.
- R4: The trial code is 0x80 after edge 1. At each decision edge the bit under trial is cleared if `cmpHigh` was 1 (DAC level above the input), and the next lower bit is set. After 8 decisions, MSB first, the code equals the input level.
- R5: Decisions happen every second edge, at edges 6, 8, ..., 20. `dacCode` does not change on the odd edges in between.
- R6: With the request released, `busyN` rises and `holdOut` falls at edge 20. Both stay asserted after every earlier edge of the conversion.
- R7: The data latch takes the final code at the edge where `busyN` rises, and at no other time.
- R8: If the request is still low at edge 20, `busyN` stays 0, `holdOut` stays 1 and the latch keeps its old value. At the first later edge where either input is high, `busyN` rises, `holdOut` falls and the latch loads the result.
- R9: `dataOe` is 1 exactly while both `csN` and `rdN` are low, with no clock delay.
- R10: A read during a conversion returns the previously latched result and neither restarts nor disturbs the conversion.
- R11: While idle and not requested, a running clock changes none of `busyN`, `holdOut`, `dacCode` or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the block acts on its falling edges |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| cmpHigh | input | 1 | Comparator flag: 1 when the DAC level is above the held input |
| busyN | output | 1 | Active-low conversion-in-progress flag |
| holdOut | output | 1 | Track/hold control: 1 = hold, 0 = track |
| dacCode | output | 8 | Current trial code to the DAC |
| dataOut | output | 8 | Output data latch contents |
| dataOe | output | 1 | Enable for the external tri-state data bus drivers |

## Verification
The bench models the comparator as a digital target and follows the trial code edge by edge.

Each corner case targets a specific fault:
- An off-by-one hold counter would assert hold at edge 2 or 4.
- A sequencer without the divide-by-two would change the code on odd edges.
- An incorrect decision polarity would fail the 0x00 and 0xFF targets.
- The stalled read, held for zero to several extra edges and released through either input, catches a design that loads the latch at edge 20 regardless of the read, or that drops busy early.
- A read pulse and a re-asserted request during a conversion catch a design that restarts on the second request or shows the result before it is complete.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_STALL = 2'd2
  } seq_state_e;

  // Strobes from control to datapath, valid for one falling edge
  typedef struct packed {
    logic start;     // load first trial code
    logic decide;    // apply comparator decision, move to next bit
    logic latchNew;  // load latch with the code being decided now
    logic latchHeld; // load latch with the finished code after a stall
  } seq_strobe_t;

endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl
  import sar_adc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HOLD_EDGE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqLow,
  output seq_strobe_t strb,
  output logic        busyN,
  output logic        holdOut
);
  // Two input edges per internal cycle, DATA_W+2 internal cycles
  localparam int CONV_EDGES = 2 * (DATA_W + 2);
  localparam int FIRST_DEC  = CONV_EDGES - 2 * (DATA_W - 1);
  localparam int CNT_W      = $clog2(CONV_EDGES + 1);
  localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(HOLD_EDGE - 1);
  localparam logic [CNT_W-1:0] DEC_CNT  = CNT_W'(FIRST_DEC - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_EDGES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] edgeCnt;
  logic             lastEdge;
  logic             intTick;

  // Divided clock phase: a decision falls on every second input edge
  assign intTick  = edgeCnt[0];
  assign lastEdge = (state == SEQ_CONV) && (edgeCnt == LAST_CNT);

  always_comb begin
    strb = '0;
    case (state)
      SEQ_IDLE:  strb.start = reqLow;
      SEQ_CONV: begin
        strb.decide   = (edgeCnt >= DEC_CNT) && intTick;
        strb.latchNew = lastEdge && !reqLow;
      end
      SEQ_STALL: strb.latchHeld = !reqLow;
      default:   strb = '0;
    endcase
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      edgeCnt <= '0;
      busyN   <= 1'b1;
      holdOut <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (reqLow) begin
            state   <= SEQ_CONV;
            edgeCnt <= CNT_W'(1);
            busyN   <= 1'b0;
          end
        end
        SEQ_CONV: begin
          edgeCnt <= edgeCnt + 1'b1;
          if (edgeCnt == HOLD_CNT) holdOut <= 1'b1;
          if (lastEdge) begin
            if (reqLow) begin
              state <= SEQ_STALL;
            end else begin
              state   <= SEQ_IDLE;
              busyN   <= 1'b1;
              holdOut <= 1'b0;
            end
          end
        end
        SEQ_STALL: begin
          if (!reqLow) begin
            state   <= SEQ_IDLE;
            busyN   <= 1'b1;
            holdOut <= 1'b0;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_datapath.sv
`timescale 1ns/1ps
module sar_datapath
  import sar_adc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic              cmpHigh,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] dataOut
);
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] nextSar;
  logic [DATA_W-1:0] latchReg;

  always_comb begin
    nextSar = sarReg;
    if (cmpHigh) nextSar = nextSar & ~bitMask;
    nextSar = nextSar | (bitMask >> 1);
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg  <= '0;
      bitMask <= '0;
    end else if (strb.start) begin
      sarReg  <= MSB_ONE;
      bitMask <= MSB_ONE;
    end else if (strb.decide) begin
      sarReg  <= nextSar;
      bitMask <= bitMask >> 1;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)               latchReg <= '0;
    else if (strb.latchNew)  latchReg <= nextSar;
    else if (strb.latchHeld) latchReg <= sarReg;
  end

  assign dacCode = sarReg;
  assign dataOut = latchReg;
endmodule

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HOLD_EDGE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              cmpHigh,
  output logic              busyN,
  output logic              holdOut,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  seq_strobe_t strb;
  logic        reqLow;

  assign reqLow = !csN && !rdN;
  assign dataOe = reqLow;

  sar_ctrl #(.DATA_W(DATA_W), .HOLD_EDGE(HOLD_EDGE)) ctrl (
    .clk(clk), .rstN(rstN), .reqLow(reqLow),
    .strb(strb), .busyN(busyN), .holdOut(holdOut)
  );

  sar_datapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .dataOut(dataOut)
  );
endmodule

// File: rtl/sar_adc_seq_chk.sv
`timescale 1ns/1ps
module sar_adc_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              busyN,
  input logic              holdOut,
  input logic [DATA_W-1:0] dacCode,
  input logic [DATA_W-1:0] dataOut
);
  // R2
  start_on_req_chk: assert property (@(negedge clk) disable iff (!rstN)
    (busyN && !csN && !rdN) |=> !busyN);

  // R6
  hold_released_at_end_chk: assert property (@(negedge clk) disable iff (!rstN)
    $rose(busyN) |-> !holdOut);

  // R3
  hold_only_while_busy_chk: assert property (@(negedge clk) disable iff (!rstN)
    $rose(holdOut) |-> !busyN);

  // R7
  latch_moves_on_busy_rise_chk: assert property (@(negedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $rose(busyN));

  // R8
  stall_keeps_busy_chk: assert property (@(negedge clk) disable iff (!rstN)
    (!busyN && !csN && !rdN) |=> !busyN);

  // R11
  idle_ignores_clock_chk: assert property (@(negedge clk) disable iff (!rstN)
    (busyN && (csN || rdN)) |=> (busyN && $stable(dacCode) && !holdOut));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.DATA_W(DATA_W)) chk (.*);

// File: tb/sar_adc_seq_test.sv
`timescale 1ns/100ps
module sar_adc_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rdN = 1'b1;
  logic [7:0] target = 8'h00;
  logic       cmpHigh;
  logic       busyN, holdOut, dataOe;
  logic [7:0] dacCode, dataOut;

  int         nChk = 0;
  int         nFail = 0;
  logic [7:0] prevLatch = 8'h00;
  bit         done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  // Comparator model: DAC level above the input
  assign cmpHigh = dacCode > target;

  sar_adc_seq uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .cmpHigh(cmpHigh),
    .busyN(busyN), .holdOut(holdOut), .dacCode(dacCode),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected trial code after j decisions
  function automatic logic [7:0] expDac(input logic [7:0] t, input int j);
    logic [7:0] keep;
    keep = (j >= 8) ? 8'hFF : ~(8'hFF >> j);
    return (t & keep) | ((j < 8) ? (8'h80 >> j) : 8'h00);
  endfunction

  function automatic int jOf(input int e);
    return (e >= 6) ? (e - 4) / 2 : 0;
  endfunction

  // Short read that does not span a falling edge
  task automatic peek(input string req);
    csN = 1'b0; rdN = 1'b0;
    #0.3;
    chk(dataOe == 1'b1, "R9", dataOe, 1);
    chk(dataOut == prevLatch, req, dataOut, prevLatch);
    csN = 1'b1; rdN = 1'b1;
  endtask

  // relEdge==0 selects a stalled read
  task automatic conv(input logic [7:0] t, input int relEdge, input int stallExtra,
                      input bit reasrt);
    target = t;
    @(posedge clk); #0.5;
    csN = 1'b0; rdN = 1'b0;
    for (int e = 1; e <= 20; e++) begin
      @(negedge clk); #1;
      if (e >= 6 && e[0] == 1'b0)
        chk(dacCode == expDac(t, jOf(e)), "R4", dacCode, expDac(t, jOf(e)));
      else
        chk(dacCode == expDac(t, jOf(e)), "R5", dacCode, expDac(t, jOf(e)));
      if (e == 1) chk(!busyN, "R2", busyN, 0);
      if (e <= 2) chk(!holdOut, "R3", holdOut, 0);
      else if (e < 20) chk(holdOut, "R3", holdOut, 1);
      if (e < 20) chk(!busyN, "R6", busyN, 0);
      if (e == 20) begin
        if (relEdge != 0) begin
          chk(busyN, "R6", busyN, 1);
          chk(!holdOut, "R6", holdOut, 0);
        end else begin
          chk(!busyN, "R8", busyN, 0);
          chk(holdOut, "R8", holdOut, 1);
          chk(dataOut == prevLatch, "R8", dataOut, prevLatch);
        end
      end
      if (relEdge != 0 && e == relEdge) begin csN = 1'b1; rdN = 1'b1; end
      if (relEdge != 0 && e == relEdge + 2) peek("R10");
      if (reasrt && e == 8) begin csN = 1'b0; rdN = 1'b0; end
      if (reasrt && e == 9) chk(dataOut == prevLatch, "R10", dataOut, prevLatch);
      if (reasrt && e == 11) begin csN = 1'b1; rdN = 1'b1; end
    end
    if (relEdge == 0) begin
      for (int s = 0; s < stallExtra; s++) begin
        @(negedge clk); #1;
        chk(!busyN, "R8", busyN, 0);
        chk(holdOut, "R8", holdOut, 1);
        chk(dataOut == prevLatch, "R10", dataOut, prevLatch);
      end
      if (t[0]) csN = 1'b1; else rdN = 1'b1;
      @(negedge clk); #1;
      chk(busyN, "R8", busyN, 1);
      chk(!holdOut, "R8", holdOut, 0);
      csN = 1'b1; rdN = 1'b1;
    end
    prevLatch = t;
    peek("R7");
  endtask

  task automatic idleRun(input int n);
    logic [7:0] savedDac;
    savedDac = dacCode;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      case ($urandom_range(0, 2))
        0: begin csN = 1'b0; rdN = 1'b1; end
        1: begin csN = 1'b1; rdN = 1'b0; end
        default: begin csN = 1'b1; rdN = 1'b1; end
      endcase
      #0.2;
      chk(dataOe == 1'b0, "R9", dataOe, 0);
      @(negedge clk); #1;
      chk(busyN, "R2", busyN, 1);
      chk(!holdOut, "R11", holdOut, 0);
      chk(dacCode == savedDac, "R11", dacCode, savedDac);
    end
    csN = 1'b1; rdN = 1'b1;
    peek("R11");
  endtask

  initial begin
    void'($urandom(32'd5150));
    #12;
    chk(busyN, "R1", busyN, 1);
    chk(!holdOut, "R1", holdOut, 0);
    chk(dacCode == 8'h00, "R1", dacCode, 0);
    chk(dataOut == 8'h00, "R1", dataOut, 0);
    chk(dataOe == 1'b0, "R9", dataOe, 0);
    @(posedge clk); #0.5;
    rstN = 1'b1;
    @(negedge clk); #1;
    peek("R1");

    conv(8'h00, 4, 0, 1'b0);
    conv(8'hFF, 0, 3, 1'b0);
    conv(8'h80, 4, 0, 1'b1);
    conv(8'h7F, 0, 0, 1'b0);
    conv(8'h01, 1, 0, 1'b0);
    idleRun(20);
    for (int k = 0; k < 14; k++) begin
      logic [7:0] t;
      t = 8'($urandom);
      if ($urandom_range(0, 1) == 1)
        conv(t, $urandom_range(1, 16), 0, 1'b0);
      else
        conv(t, 0, $urandom_range(0, 5), 1'b0);
      if (k == 7) idleRun(8);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R6 actual 0 expected 1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule